// File: doc/BRIEF.md
# Next Instruction Address Unit

This block owns the program counter of a 32-bit core whose instructions are all four bytes long. Each cycle it takes the decoded kind of control transfer together with a 16-bit branch offset, a 26-bit jump field and the two source register values. It then chooses the next instruction address: the sequential address, a PC-relative branch target, an absolute jump inside the current 256 MB region, or a target taken from a register. There is no delay slot. All targets are formed from PC+4, the address of the following instruction.

The block tests equality, inequality and the four signed comparisons against zero. It also produces the return address and a write request aimed at register 31 for calls. A register target that is not word aligned raises a fault flag and leaves the PC unchanged. A low step enable freezes the PC.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` is loaded with the parameter `RESET_VEC` (default 0).
- R2: With `xfer_kind` = 0 (sequential), and for every unused code 9 to 15, `next_pc` is `pc_q`+4 and no link write occurs.
- R3: Code 1 takes the branch when `rs_val` equals `rt_val`. Code 2 takes it when they differ.
- R4: Codes 3, 4, 5 and 6 take the branch when `rs_val` as a signed number is below zero, above zero, at most zero, or at least zero, respectively.
- R5: A taken branch gives `next_pc` = `pc_q`+4 + (sign-extended `br_disp` × 4). A branch that is not taken gives `pc_q`+4.
- R6: Code 7 (direct jump) gives `next_pc` = {bits 31:28 of `pc_q`+4, `jmp_field`, 2'b00}.
- R7: Code 8 (register jump) gives `next_pc` = `rs_val`.
- R8: `link_addr` is always `pc_q`+4, and `link_idx` is 31. `link_we` is high exactly when `step_en` and `link_req` are high, `xfer_kind` is one of 1 to 8, and no address fault is present. A branch with link writes the link whether or not it is taken.
- R9: With code 8 and `rs_val[1:0]` not zero, `addr_fault` is high, `link_we` is low and `pc_q` keeps its value at the next edge.
- R10: When `step_en` is low, `pc_q` keeps its value and `link_we` is low. When it is high and there is no fault, `pc_q` takes `next_pc` at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the PC this cycle |
| xfer_kind | input | 4 | Control-transfer code (0 sequential, 1..6 branches, 7 jump, 8 register jump) |
| link_req | input | 1 | Transfer also saves the return address |
| br_disp | input | 16 | Signed branch offset in words |
| jmp_field | input | 26 | Direct jump word address within the region |
| rs_val | input | 32 | First register operand, also the register jump target |
| rt_val | input | 32 | Second register operand |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Address loaded at the next enabled edge |
| link_addr | output | 32 | Return address (PC+4) |
| link_we | output | 1 | Request to write the return address |
| link_idx | output | 5 | Destination register of the link write (31) |
| addr_fault | output | 1 | Misaligned register jump target |

## Verification
The assertions assume that `rst` is high at the first clock edge, so the PC starts from a known, word-aligned value. They also assume that `xfer_kind` and the operands stay steady between a falling edge and the next rising edge. The bench drives every input on the falling edge and holds reset through the first rising edge. The alignment property holds only if every register target without a fault is word aligned. The bench therefore uses misaligned `rs_val` values only on register jumps, where they are meant to fault, or on codes that ignore `rs_val` as a target.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN      = 32;
  localparam int DISP_W    = 16;
  localparam int JFIELD_W  = 26;
  localparam int RIDX_W    = 5;
  localparam int KIND_W    = 4;
  localparam int REGION_W  = XLEN - JFIELD_W - 2;
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  typedef enum logic [KIND_W-1:0] {
    XK_SEQ  = 4'd0,
    XK_BEQ  = 4'd1,
    XK_BNE  = 4'd2,
    XK_BLTZ = 4'd3,
    XK_BGTZ = 4'd4,
    XK_BLEZ = 4'd5,
    XK_BGEZ = 4'd6,
    XK_JUMP = 4'd7,
    XK_JREG = 4'd8
  } xfer_kind_e;

  function automatic logic [XLEN-1:0] f_branch_target(
    input logic [XLEN-1:0]   seq_addr,
    input logic [DISP_W-1:0] disp
  );
    logic [XLEN-1:0] off;
    off = {{(XLEN-DISP_W-2){disp[DISP_W-1]}}, disp, 2'b00};
    return seq_addr + off;
  endfunction

  function automatic logic [XLEN-1:0] f_jump_target(
    input logic [XLEN-1:0]     seq_addr,
    input logic [JFIELD_W-1:0] field
  );
    return {seq_addr[XLEN-1 -: REGION_W], field, 2'b00};
  endfunction

  function automatic logic f_is_branch(input logic [KIND_W-1:0] k);
    return (k >= KIND_W'(XK_BEQ)) && (k <= KIND_W'(XK_BGEZ));
  endfunction

  function automatic logic f_is_xfer(input logic [KIND_W-1:0] k);
    return (k >= KIND_W'(XK_BEQ)) && (k <= KIND_W'(XK_JREG));
  endfunction
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  output logic              taken
);
  logic rs_neg, rs_zero, same;
  assign rs_neg  = rs_val[XLEN-1];
  assign rs_zero = (rs_val == '0);
  assign same    = (rs_val == rt_val);

  always_comb begin
    case (kind)
      KIND_W'(XK_BEQ):  taken = same;
      KIND_W'(XK_BNE):  taken = !same;
      KIND_W'(XK_BLTZ): taken = rs_neg;
      KIND_W'(XK_BGTZ): taken = !rs_neg && !rs_zero;
      KIND_W'(XK_BLEZ): taken = rs_neg || rs_zero;
      KIND_W'(XK_BGEZ): taken = !rs_neg;
      default:          taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]     pc_cur,
  input  logic [DISP_W-1:0]   disp,
  input  logic [JFIELD_W-1:0] field,
  output logic [XLEN-1:0]     seq_addr,
  output logic [XLEN-1:0]     br_addr,
  output logic [XLEN-1:0]     jmp_addr
);
  assign seq_addr = pc_cur + INSN_BYTES;
  assign br_addr  = f_branch_target(seq_addr, disp);
  assign jmp_addr = f_jump_target(seq_addr, field);
endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg
  import npc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= RESET_VEC;
    else if (load) q <= d;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [XLEN-1:0]   RESET_VEC = '0,
  parameter logic [RIDX_W-1:0] LINK_REG  = RIDX_W'(31)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_en,
  input  logic [KIND_W-1:0]   xfer_kind,
  input  logic                link_req,
  input  logic [DISP_W-1:0]   br_disp,
  input  logic [JFIELD_W-1:0] jmp_field,
  input  logic [XLEN-1:0]     rs_val,
  input  logic [XLEN-1:0]     rt_val,
  output logic [XLEN-1:0]     pc_q,
  output logic [XLEN-1:0]     next_pc,
  output logic [XLEN-1:0]     link_addr,
  output logic                link_we,
  output logic [RIDX_W-1:0]   link_idx,
  output logic                addr_fault
);
  logic [XLEN-1:0] seq_addr, br_addr, jmp_addr;
  logic            br_taken;
  logic            is_jreg;
  logic            pc_load;

  npc_cond u_cond (
    .kind   (xfer_kind),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .taken  (br_taken)
  );

  npc_target u_target (
    .pc_cur   (pc_q),
    .disp     (br_disp),
    .field    (jmp_field),
    .seq_addr (seq_addr),
    .br_addr  (br_addr),
    .jmp_addr (jmp_addr)
  );

  assign is_jreg    = (xfer_kind == KIND_W'(XK_JREG));
  assign addr_fault = is_jreg && (rs_val[1:0] != 2'b00);

  always_comb begin
    if (f_is_branch(xfer_kind))                 next_pc = br_taken ? br_addr : seq_addr;
    else if (xfer_kind == KIND_W'(XK_JUMP))     next_pc = jmp_addr;
    else if (is_jreg)                           next_pc = addr_fault ? pc_q : rs_val;
    else                                        next_pc = seq_addr;
  end

  assign pc_load   = step_en && !addr_fault;
  assign link_addr = seq_addr;
  assign link_idx  = LINK_REG;
  assign link_we   = step_en && link_req && f_is_xfer(xfer_kind) && !addr_fault;

  npc_pcreg #(.RESET_VEC(RESET_VEC)) u_pcreg (
    .clk  (clk),
    .rst  (rst),
    .load (pc_load),
    .d    (next_pc),
    .q    (pc_q)
  );
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              step_en,
  input logic [KIND_W-1:0] xfer_kind,
  input logic [XLEN-1:0]   pc_q,
  input logic              addr_fault,
  input logic              link_we
);
  p_reset_vec_r1: assert property (@(posedge clk) rst |=> pc_q == RESET_VEC);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (step_en && xfer_kind == KIND_W'(XK_SEQ)) |=> pc_q == $past(pc_q) + INSN_BYTES);

  p_seq_no_link_r2: assert property (@(posedge clk) disable iff (rst)
    (xfer_kind == KIND_W'(XK_SEQ)) |-> !link_we);

  p_fault_hold_r9: assert property (@(posedge clk) disable iff (rst)
    addr_fault |=> $stable(pc_q));

  p_fault_no_link_r9: assert property (@(posedge clk) disable iff (rst)
    addr_fault |-> !link_we);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(pc_q));

  p_stall_no_link_r10: assert property (@(posedge clk) disable iff (rst)
    !step_en |-> !link_we);

  p_word_aligned_r10: assert property (@(posedge clk) disable iff (rst)
    step_en |=> pc_q[1:0] == 2'b00);
endmodule

bind npc_unit npc_unit_chk #(.RESET_VEC(RESET_VEC)) u_npc_chk (
  .clk        (clk),
  .rst        (rst),
  .step_en    (step_en),
  .xfer_kind  (xfer_kind),
  .pc_q       (pc_q),
  .addr_fault (addr_fault),
  .link_we    (link_we)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic [3:0]  xfer_kind = 4'd0;
  logic        link_req = 1'b0;
  logic [15:0] br_disp = '0;
  logic [25:0] jmp_field = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] pc_q, next_pc, link_addr;
  logic        link_we, addr_fault;
  logic [4:0]  link_idx;

  int checks = 0;
  int failures = 0;
  logic [31:0] model_pc;

  always #5 clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst(rst), .step_en(step_en), .xfer_kind(xfer_kind),
    .link_req(link_req), .br_disp(br_disp), .jmp_field(jmp_field),
    .rs_val(rs_val), .rt_val(rt_val), .pc_q(pc_q), .next_pc(next_pc),
    .link_addr(link_addr), .link_we(link_we), .link_idx(link_idx),
    .addr_fault(addr_fault)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic model_taken(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b);
    case (k)
      4'd1: return a == b;
      4'd2: return a != b;
      4'd3: return $signed(a) < 0;
      4'd4: return $signed(a) > 0;
      4'd5: return $signed(a) <= 0;
      4'd6: return $signed(a) >= 0;
      default: return 1'b0;
    endcase
  endfunction

  // Applies one operation, checks outputs, clocks it, checks the PC.
  task automatic apply(input string req, input logic [3:0] k, input logic lnk,
                       input logic [15:0] d, input logic [25:0] jf,
                       input logic [31:0] a, input logic [31:0] b, input logic en);
    logic [31:0] ret, tgt;
    logic        flt, lw;
    @(negedge clk);
    step_en = en; xfer_kind = k; link_req = lnk; br_disp = d;
    jmp_field = jf; rs_val = a; rt_val = b;
    ret = model_pc + 32'd4;
    flt = (k == 4'd8) && (a % 4 != 0);
    if (k >= 4'd1 && k <= 4'd6)
      tgt = model_taken(k, a, b) ? 32'($signed(ret) + $signed(d) * 4) : ret;
    else if (k == 4'd7)
      tgt = (ret & 32'hF000_0000) | ({6'd0, jf} * 4);
    else if (k == 4'd8)
      tgt = flt ? model_pc : a;
    else
      tgt = ret;
    lw = en && lnk && (k >= 4'd1) && (k <= 4'd8) && !flt;
    #1;
    chk(req, "next_pc", next_pc, tgt);
    chk(req, "addr_fault", {31'd0, addr_fault}, {31'd0, flt});
    chk("R8", "link_we", {31'd0, link_we}, {31'd0, lw});
    chk("R8", "link_addr", link_addr, ret);
    @(posedge clk);
    #1;
    if (en && !flt) model_pc = tgt;
    chk(req, "pc_q after edge", pc_q, model_pc);
  endtask

  task automatic t_reset_r1;
    rst = 1'b1;
    @(posedge clk); #1;
    model_pc = 32'h0;
    chk("R1", "pc_q at reset", pc_q, 32'h0);
    chk("R8", "link_idx", {27'd0, link_idx}, 32'd31);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_sequential_r2;
    apply("R2", 4'd0, 1'b0, 16'h0, 26'h0, 32'h5, 32'h0, 1'b1);
    apply("R2", 4'd0, 1'b1, 16'h0, 26'h0, 32'h0, 32'h0, 1'b1);
    for (int k = 9; k < 16; k++)
      apply("R2", 4'(k), 1'b1, 16'h7, 26'h3, 32'h40, 32'h40, 1'b1);
  endtask

  task automatic t_equality_r3;
    apply("R3", 4'd1, 1'b0, 16'h0004, 26'h0, 32'h1234, 32'h1234, 1'b1);
    apply("R3", 4'd1, 1'b0, 16'h0004, 26'h0, 32'h1234, 32'h1235, 1'b1);
    apply("R3", 4'd2, 1'b0, 16'h0003, 26'h0, 32'h1, 32'h2, 1'b1);
    apply("R3", 4'd2, 1'b0, 16'h0003, 26'h0, 32'h9, 32'h9, 1'b1);
  endtask

  task automatic t_signed_r4;
    logic [31:0] vals [3];
    vals[0] = 32'hFFFF_FFFF; vals[1] = 32'h0; vals[2] = 32'h7FFF_FFFF;
    for (int k = 3; k <= 6; k++)
      for (int v = 0; v < 3; v++)
        apply("R4", 4'(k), 1'b0, 16'h0002, 26'h0, vals[v], 32'h0, 1'b1);
    apply("R4", 4'd3, 1'b0, 16'h0002, 26'h0, 32'h8000_0000, 32'h0, 1'b1);
  endtask

  task automatic t_branch_target_r5;
    apply("R5", 4'd1, 1'b0, 16'hFFFE, 26'h0, 32'h0, 32'h0, 1'b1);
    apply("R5", 4'd1, 1'b0, 16'h7FFF, 26'h0, 32'h0, 32'h0, 1'b1);
    apply("R5", 4'd1, 1'b0, 16'h8000, 26'h0, 32'h0, 32'h0, 1'b1);
  endtask

  task automatic t_jump_r6_r7;
    apply("R7", 4'd8, 1'b0, 16'h0, 26'h0, 32'h7FFF_FFFC, 32'h0, 1'b1);
    apply("R6", 4'd7, 1'b0, 16'h0, 26'h2AB_CDEF, 32'h0, 32'h0, 1'b1);
    chk("R6", "region from pc+4", pc_q & 32'hF000_0000, 32'h8000_0000);
    apply("R7", 4'd8, 1'b0, 16'h0, 26'h0, 32'h0000_1000, 32'h0, 1'b1);
    apply("R6", 4'd7, 1'b0, 16'h0, 26'h000_0010, 32'h0, 32'h0, 1'b1);
  endtask

  task automatic t_link_r8;
    apply("R8", 4'd7, 1'b1, 16'h0, 26'h000_0100, 32'h0, 32'h0, 1'b1);
    apply("R8", 4'd8, 1'b1, 16'h0, 26'h0, 32'h0000_2000, 32'h0, 1'b1);
    apply("R8", 4'd1, 1'b1, 16'h0010, 26'h0, 32'h1, 32'h2, 1'b1);
    apply("R8", 4'd6, 1'b1, 16'h0010, 26'h0, 32'h1, 32'h0, 1'b1);
  endtask

  task automatic t_fault_r9;
    apply("R9", 4'd8, 1'b1, 16'h0, 26'h0, 32'h0000_3002, 32'h0, 1'b1);
    apply("R9", 4'd8, 1'b0, 16'h0, 26'h0, 32'h0000_3001, 32'h0, 1'b1);
    apply("R9", 4'd8, 1'b1, 16'h0, 26'h0, 32'h0000_3000, 32'h0, 1'b1);
  endtask

  task automatic t_stall_r10;
    apply("R10", 4'd0, 1'b0, 16'h0, 26'h0, 32'h0, 32'h0, 1'b0);
    apply("R10", 4'd7, 1'b1, 16'h0, 26'h000_0040, 32'h0, 32'h0, 1'b0);
    apply("R10", 4'd1, 1'b1, 16'h0008, 26'h0, 32'h0, 32'h0, 1'b0);
    apply("R10", 4'd0, 1'b0, 16'h0, 26'h0, 32'h0, 32'h0, 1'b1);
  endtask

  initial begin
    model_pc = 32'h0;
    t_reset_r1;
    t_sequential_r2;
    t_equality_r3;
    t_signed_r4;
    t_branch_target_r5;
    t_jump_r6_r7;
    t_link_r8;
    t_fault_r9;
    t_stall_r10;
    t_reset_r1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule